// File: doc/BRIEF.md
# Monitoring Event Selection Filter

This block sits at the end of event building and decides, once per completed event, whether that event is copied into a monitoring readout pipe. For each event it receives the error vector, a flag set by upstream selection logic, the trigger type, the event length in 32-bit words and the current empty status of the monitoring pipe. Static configuration supplies an error mute mask, an accepted trigger type, a mute for the global size error, and enables for error-based selection, flag-based selection, trigger-type gating, send-all mode and event formatting as a whole.

Error-based and flag-based selection are evaluated side by side and either one makes the event a candidate. When neither applies, trigger-type gating acts as the fallback. A candidate is then forwarded either unconditionally (send-all) or only when the pipe is empty, so that in the second mode at most one event waits for readout. Events longer than the pipe can hold are always skipped. The registered decision appears one cycle after the event is taken, with a reason code, and two 32-bit counters tally accepted and rejected events since the last run start.

Top module: `mon_event_filter`

## Requirements
- R1: With error selection enabled, an event is a candidate when `err_vec & ~cfg_err_mute` is non-zero; error bits covered by the mute mask alone do not make it a candidate.
- R2: With flag selection enabled, an event whose `fw_sel` is 1 is a candidate, independently of R1; either condition suffices.
- R3: When neither R1 nor R2 makes the event a candidate and trigger-type gating is disabled, the event is a candidate.
- R4: When neither R1 nor R2 applies and gating is enabled, the event is a candidate only if `trig_type` equals `cfg_tt_accept`, except that `cfg_tt_accept` = 0x00 admits every trigger type.
- R5: With `cfg_send_all` = 1 every candidate is accepted; with it 0 a candidate is accepted only if `pipe_empty` = 1, and otherwise rejected with reason 2 (busy).
- R6: An event with `evt_len` greater than 4096 is always rejected with reason 3 (oversize); `dec_size_err` is 1 for it unless `cfg_size_mute` = 1, and is 0 for every other decision.
- R7: With `cfg_fmt_en` = 0 every event is rejected with reason 1 (filtered), whatever its other inputs.
- R8: An event taken with `evt_valid` = 1 produces `dec_valid` = 1 for exactly one cycle on the next clock edge; reason encoding is 0 accepted, 1 filtered (non-candidate), 2 busy, 3 oversize; `dec_accept` = 1 exactly when reason is 0. Priority: format disable, then oversize, then non-candidate, then busy.
- R9: `acc_count` and `rej_count` increment on the edge where an accepted or rejected decision is registered; `run_start` clears both and takes precedence over an increment in the same cycle.
- R10: After reset `dec_valid` is 0, both counters are 0, and `evt_ready` is 1 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Completed event offered for a decision |
| evt_ready | output | 1 | Block can take an event this cycle |
| err_vec | input | 32 | Event error flags |
| fw_sel | input | 1 | Event marked by upstream selection logic |
| trig_type | input | 8 | Event trigger type |
| evt_len | input | 16 | Event length in 32-bit words |
| pipe_empty | input | 1 | Monitoring pipe currently empty |
| cfg_fmt_en | input | 1 | Global format enable |
| cfg_err_sel | input | 1 | Enable error-based selection |
| cfg_flt_sel | input | 1 | Enable flag-based selection |
| cfg_tt_gate | input | 1 | Enable trigger-type gating |
| cfg_send_all | input | 1 | Forward every candidate |
| cfg_err_mute | input | 32 | Mask of error bits ignored by selection |
| cfg_size_mute | input | 1 | Suppress the global size error |
| cfg_tt_accept | input | 8 | Accepted trigger type, 0 admits all |
| run_start | input | 1 | Clears both counters |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Event is copied to the pipe |
| dec_reason | output | 2 | 0 accepted, 1 filtered, 2 busy, 3 oversize |
| dec_size_err | output | 1 | Global size error raised |
| acc_count | output | 32 | Accepted events since run start |
| rej_count | output | 32 | Rejected events since run start |

## Verification
The hardest situation to reach is an event whose only error bits are all muted while trigger gating is on and the trigger type misses, because random error vectors and mute masks almost never cancel exactly and the fallback path then looks like an error-driven accept. The stimulus builds such events directly by drawing the mute mask first and deriving the error vector as a subset of it, and mixes that with boundary lengths of 4096 and 4097, the wildcard trigger value and a run start coinciding with a decision. Random events draw trigger types from a small set so that matches against the accepted type occur often.

// File: rtl/mef_pkg.sv
package mef_pkg;
  typedef enum logic [1:0] {
    RSN_ACCEPT   = 2'd0,
    RSN_FILTERED = 2'd1,
    RSN_BUSY     = 2'd2,
    RSN_OVERSIZE = 2'd3
  } reason_e;
endpackage

// File: rtl/mef_select.sv
// Candidate selection: error and flag paths in parallel, trigger-type fallback.
module mef_select #(
  parameter int ERR_W = 32,
  parameter int TT_W  = 8
) (
  input  logic [ERR_W-1:0] err_vec,
  input  logic [ERR_W-1:0] err_mute,
  input  logic             fw_sel,
  input  logic [TT_W-1:0]  trig_type,
  input  logic [TT_W-1:0]  tt_accept,
  input  logic             err_sel_en,
  input  logic             flt_sel_en,
  input  logic             tt_gate_en,
  output logic             candidate
);
  logic err_hit;
  logic flt_hit;
  logic tt_wild;
  logic tt_match;
  logic fallback;

  always_comb begin
    err_hit  = err_sel_en && (|(err_vec & ~err_mute));
    flt_hit  = flt_sel_en && fw_sel;
    tt_wild  = (tt_accept == '0);
    tt_match = tt_wild || (trig_type == tt_accept);
    fallback = !tt_gate_en || tt_match;
    candidate = err_hit || flt_hit || fallback;
  end
endmodule

// File: rtl/mef_gate.sv
// Final accept/reject decision with reason priority.
module mef_gate
  import mef_pkg::*;
(
  input  logic    fmt_en,
  input  logic    oversize,
  input  logic    size_mute,
  input  logic    candidate,
  input  logic    send_all,
  input  logic    pipe_empty,
  output logic    accept,
  output reason_e reason,
  output logic    size_err
);
  always_comb begin
    size_err = 1'b0;
    if (!fmt_en) begin
      reason = RSN_FILTERED;
    end else if (oversize) begin
      reason   = RSN_OVERSIZE;
      size_err = !size_mute;
    end else if (!candidate) begin
      reason = RSN_FILTERED;
    end else if (!send_all && !pipe_empty) begin
      reason = RSN_BUSY;
    end else begin
      reason = RSN_ACCEPT;
    end
    accept = (reason == RSN_ACCEPT);
  end
endmodule

// File: rtl/mef_counter.sv
// Event tally with synchronous clear taking precedence over increment.
module mef_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/mon_event_filter.sv
module mon_event_filter
  import mef_pkg::*;
#(
  parameter int ERR_W     = 32,
  parameter int TT_W      = 8,
  parameter int LEN_W     = 16,
  parameter int MAX_WORDS = 4096,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [ERR_W-1:0] err_vec,
  input  logic             fw_sel,
  input  logic [TT_W-1:0]  trig_type,
  input  logic [LEN_W-1:0] evt_len,
  input  logic             pipe_empty,
  input  logic             cfg_fmt_en,
  input  logic             cfg_err_sel,
  input  logic             cfg_flt_sel,
  input  logic             cfg_tt_gate,
  input  logic             cfg_send_all,
  input  logic [ERR_W-1:0] cfg_err_mute,
  input  logic             cfg_size_mute,
  input  logic [TT_W-1:0]  cfg_tt_accept,
  input  logic             run_start,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic [1:0]       dec_reason,
  output logic             dec_size_err,
  output logic [CNT_W-1:0] acc_count,
  output logic [CNT_W-1:0] rej_count
);
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_WORDS);

  logic    take;
  logic    candidate;
  logic    oversize;
  logic    nx_accept;
  reason_e nx_reason;
  logic    nx_size_err;

  assign evt_ready = !rst;
  assign take      = evt_valid && evt_ready;
  assign oversize  = (evt_len > LEN_LIMIT);

  mef_select #(.ERR_W(ERR_W), .TT_W(TT_W)) u_select (
    .err_vec    (err_vec),
    .err_mute   (cfg_err_mute),
    .fw_sel     (fw_sel),
    .trig_type  (trig_type),
    .tt_accept  (cfg_tt_accept),
    .err_sel_en (cfg_err_sel),
    .flt_sel_en (cfg_flt_sel),
    .tt_gate_en (cfg_tt_gate),
    .candidate  (candidate)
  );

  mef_gate u_gate (
    .fmt_en     (cfg_fmt_en),
    .oversize   (oversize),
    .size_mute  (cfg_size_mute),
    .candidate  (candidate),
    .send_all   (cfg_send_all),
    .pipe_empty (pipe_empty),
    .accept     (nx_accept),
    .reason     (nx_reason),
    .size_err   (nx_size_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_reason   <= RSN_ACCEPT;
      dec_size_err <= 1'b0;
    end else begin
      dec_valid <= take;
      if (take) begin
        dec_accept   <= nx_accept;
        dec_reason   <= nx_reason;
        dec_size_err <= nx_size_err;
      end else begin
        dec_accept   <= 1'b0;
        dec_size_err <= 1'b0;
      end
    end
  end

  mef_counter #(.CNT_W(CNT_W)) u_acc_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (run_start),
    .inc   (take && nx_accept),
    .count (acc_count)
  );

  mef_counter #(.CNT_W(CNT_W)) u_rej_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (run_start),
    .inc   (take && !nx_accept),
    .count (rej_count)
  );
endmodule

// File: rtl/mon_event_filter_chk.sv
module mon_event_filter_chk #(
  parameter int LEN_W     = 16,
  parameter int MAX_WORDS = 4096,
  parameter int CNT_W     = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic [LEN_W-1:0] evt_len,
  input logic             pipe_empty,
  input logic             cfg_fmt_en,
  input logic             cfg_send_all,
  input logic             run_start,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [1:0]       dec_reason,
  input logic             dec_size_err,
  input logic [CNT_W-1:0] acc_count,
  input logic [CNT_W-1:0] rej_count
);
  AST_DEC_STROBE: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_ready) |=> dec_valid) else $error("strobe");   // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !(evt_valid && evt_ready) |=> !dec_valid) else $error("spurious"); // R8
  AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_accept == (dec_reason == 2'd0))) else $error("code"); // R8
  AST_FMT_OFF: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !cfg_fmt_en) |=> (!dec_accept && dec_reason == 2'd1)) else $error("fmt"); // R7
  AST_OVERSIZE: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && cfg_fmt_en && evt_len > LEN_W'(MAX_WORDS)) |=> (dec_reason == 2'd3)) else $error("size"); // R6
  AST_SIZE_ERR_SCOPE: assert property (@(posedge clk) disable iff (rst)
    dec_size_err |-> (dec_valid && dec_reason == 2'd3)) else $error("sizeerr"); // R6
  AST_PIPE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !cfg_send_all && !pipe_empty) |=> !dec_accept) else $error("busy"); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    run_start |=> (acc_count == '0 && rej_count == '0)) else $error("clr"); // R9
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !run_start) |=> (acc_count + rej_count == $past(acc_count) + $past(rej_count) + 1'b1)) else $error("step"); // R9
endmodule

bind mon_event_filter mon_event_filter_chk #(
  .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .evt_valid    (evt_valid),
  .evt_ready    (evt_ready),
  .evt_len      (evt_len),
  .pipe_empty   (pipe_empty),
  .cfg_fmt_en   (cfg_fmt_en),
  .cfg_send_all (cfg_send_all),
  .run_start    (run_start),
  .dec_valid    (dec_valid),
  .dec_accept   (dec_accept),
  .dec_reason   (dec_reason),
  .dec_size_err (dec_size_err),
  .acc_count    (acc_count),
  .rej_count    (rej_count)
);

// File: tb/mon_event_filter_bench.sv
module mon_event_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [31:0] err_vec = '0;
  logic        fw_sel = 1'b0;
  logic [7:0]  trig_type = '0;
  logic [15:0] evt_len = '0;
  logic        pipe_empty = 1'b1;
  logic        cfg_fmt_en = 1'b1;
  logic        cfg_err_sel = 1'b0;
  logic        cfg_flt_sel = 1'b0;
  logic        cfg_tt_gate = 1'b0;
  logic        cfg_send_all = 1'b1;
  logic [31:0] cfg_err_mute = '0;
  logic        cfg_size_mute = 1'b0;
  logic [7:0]  cfg_tt_accept = '0;
  logic        run_start = 1'b0;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_reason;
  logic        dec_size_err;
  logic [31:0] acc_count;
  logic [31:0] rej_count;

  int checks = 0;
  int fails = 0;
  int unsigned m_acc = 0;
  int unsigned m_rej = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_event_filter u_mon_event_filter (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .err_vec(err_vec), .fw_sel(fw_sel), .trig_type(trig_type), .evt_len(evt_len),
    .pipe_empty(pipe_empty), .cfg_fmt_en(cfg_fmt_en), .cfg_err_sel(cfg_err_sel),
    .cfg_flt_sel(cfg_flt_sel), .cfg_tt_gate(cfg_tt_gate), .cfg_send_all(cfg_send_all),
    .cfg_err_mute(cfg_err_mute), .cfg_size_mute(cfg_size_mute),
    .cfg_tt_accept(cfg_tt_accept), .run_start(run_start), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_reason(dec_reason), .dec_size_err(dec_size_err),
    .acc_count(acc_count), .rej_count(rej_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected reason from the requirements (R1..R8).
  function automatic logic [1:0] exp_reason();
    logic cand;
    if (!cfg_fmt_en) return 2'd1;                                   // R7
    if (evt_len > 16'd4096) return 2'd3;                            // R6
    cand = (cfg_err_sel && ((err_vec & ~cfg_err_mute) != 0))        // R1
        || (cfg_flt_sel && fw_sel)                                  // R2
        || !cfg_tt_gate                                             // R3
        || cfg_tt_accept == 8'h00 || trig_type == cfg_tt_accept;    // R4
    if (!cand) return 2'd1;
    if (!cfg_send_all && !pipe_empty) return 2'd2;                  // R5
    return 2'd0;
  endfunction

  task automatic send(string req, bit with_start = 1'b0);
    logic [1:0] er;
    logic       es;
    @(negedge clk);
    evt_valid = 1'b1;
    run_start = with_start;
    er = exp_reason();
    es = (er == 2'd3) && !cfg_size_mute;
    if (with_start) begin m_acc = 0; m_rej = 0; end
    else if (er == 2'd0) m_acc++;
    else m_rej++;
    @(negedge clk);
    evt_valid = 1'b0;
    run_start = 1'b0;
    check({req, " R8 valid"}, dec_valid, 1);
    check({req, " reason"}, dec_reason, er);
    check({req, " R8 accept"}, dec_accept, er == 2'd0);
    check({req, " R6 size_err"}, dec_size_err, es);
    check({req, " R9 acc"}, acc_count, m_acc);
    check({req, " R9 rej"}, rej_count, m_rej);
    @(negedge clk);
    check({req, " R8 pulse"}, dec_valid, 0);
  endtask

  task automatic base_cfg();
    cfg_fmt_en = 1; cfg_err_sel = 0; cfg_flt_sel = 0; cfg_tt_gate = 0;
    cfg_send_all = 1; cfg_err_mute = '0; cfg_size_mute = 0; cfg_tt_accept = '0;
    err_vec = '0; fw_sel = 0; trig_type = '0; evt_len = 16'd100; pipe_empty = 1;
  endtask

  initial begin
    void'($urandom(32'd1357));
    base_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 valid", dec_valid, 0);
    check("R10 acc", acc_count, 0);
    check("R10 rej", rej_count, 0);
    check("R10 ready", evt_ready, 1);

    // R3 fallback with gating off
    send("R3");
    // R4 gating: mismatch, match, wildcard
    cfg_tt_gate = 1; cfg_tt_accept = 8'h05; trig_type = 8'h06; send("R4 miss");
    trig_type = 8'h05; send("R4 hit");
    cfg_tt_accept = 8'h00; trig_type = 8'h77; send("R4 wild");
    // R1 error path: muted only vs unmuted
    cfg_tt_accept = 8'h05; trig_type = 8'h06; cfg_err_sel = 1;
    cfg_err_mute = 32'h0000_00F0; err_vec = 32'h0000_0030; send("R1 muted");
    err_vec = 32'h0100_0030; send("R1 unmuted");
    // R2 flag path in parallel
    err_vec = '0; cfg_flt_sel = 1; fw_sel = 1; send("R2 flag");
    cfg_flt_sel = 0; send("R2 off");
    // R5 busy vs send-all
    base_cfg(); cfg_send_all = 0; pipe_empty = 0; send("R5 busy");
    pipe_empty = 1; send("R5 empty");
    cfg_send_all = 1; pipe_empty = 0; send("R5 all");
    // R6 length boundary and mute
    evt_len = 16'd4096; send("R6 4096");
    evt_len = 16'd4097; send("R6 4097");
    cfg_size_mute = 1; send("R6 muted");
    cfg_size_mute = 0; cfg_send_all = 0; evt_len = 16'hFFFF; send("R6 prio");
    // R7 format disabled
    base_cfg(); cfg_fmt_en = 0; send("R7 off");
    evt_len = 16'd5000; send("R7 prio");
    // R9 run_start alone and with a decision
    base_cfg();
    @(negedge clk); run_start = 1; m_acc = 0; m_rej = 0;
    @(negedge clk); run_start = 0;
    check("R9 clr acc", acc_count, 0);
    check("R9 clr rej", rej_count, 0);
    send("R9 a"); send("R9 b");
    send("R9 clr-wins", 1'b1);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      cfg_fmt_en    = ($urandom_range(0, 15) != 0);
      cfg_err_sel   = $urandom_range(0, 1);
      cfg_flt_sel   = $urandom_range(0, 1);
      cfg_tt_gate   = ($urandom_range(0, 3) != 0);
      cfg_send_all  = $urandom_range(0, 1);
      cfg_size_mute = $urandom_range(0, 1);
      cfg_tt_accept = ($urandom_range(0, 4) == 0) ? 8'h00 : 8'($urandom_range(1, 4));
      cfg_err_mute  = $urandom();
      err_vec       = ($urandom_range(0, 1) != 0) ? (cfg_err_mute & $urandom())
                                                  : (($urandom_range(0, 2) == 0) ? $urandom() : 32'h0);
      fw_sel        = $urandom_range(0, 1);
      trig_type     = 8'($urandom_range(0, 4));
      evt_len       = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(4095, 4098))
                                                  : 16'($urandom_range(1, 4096));
      pipe_empty    = $urandom_range(0, 1);
      send("RND", $urandom_range(0, 99) == 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule